// File: doc/BRIEF.md
# Counter Bank Global Control

This block sits between a set of general-purpose event counters, a smaller set of fixed-function counters and the core. It holds the shared control state for the whole bank: a global enable vector, a sticky overflow status vector with a mask-clear write, and a packed control word for the fixed counters. From this state it drives the run enable of each counter. It gathers the counters' overflow pulses into status bits and turns the qualifying ones into one interrupt line.

Both banks share a single 64-bit bit space. General counter `i` owns bit `i`, and fixed counter `j` owns bit `32+j`. A combinational read port takes a 32-bit index word and returns a counter value. The index word picks the bank, the counter number and an optional 32-bit truncation. Each counter value is zero-extended from its own bank's width. Registers are written through a single-cycle write strobe with a 2-bit register select, and every write takes effect at the next clock edge.

Top module: `ctr_bank_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, the enable, status and fixed-control outputs are zero and `pmi_o` is low.
- R2: A write with select 0 loads the enable vector. Only bits 0..NUM_GP-1 and 32..32+NUM_FX-1 are stored and the other bits read 0. `gp_run_o[i]` equals enable bit `i`.
- R3: A write with select 2 loads the fixed-control word. Counter `j` owns the nibble at bits 4j+3..4j, where bit 0 enables supervisor counting, bit 1 enables user counting and bit 3 enables an interrupt on overflow. Nibble bit 2 and all bits above the last nibble read 0. `fx_run_o[j]` is enable bit 32+j ANDed with (nibble bit 0 OR bit 1), so a zeroed nibble stops the counter.
- R4: An overflow pulse on general counter `i` sets status bit `i`, and one on fixed counter `j` sets status bit `32+j`, visible from the next cycle. The bit then stays set.
- R5: A write with select 1 clears exactly the status bits that are 1 in the write data and leaves the other bits unchanged.
- R6: When an overflow pulse and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: `pmi_o` is high for the one cycle after a cycle that has an overflow whose interrupt enable is set. For a general counter the enable is `gp_int_en_i[i]`; for a fixed counter it is nibble bit 3. Otherwise `pmi_o` is low, even though status is still set.
- R8: On the read port, index bit 30 selects the fixed bank (1) or the general bank (0), and bits 29..0 give the counter number. The data is that counter's value zero-extended from its bank's width.
- R9: When index bit 31 is set, bits 63..32 of the read data are zero and the low 32 bits are returned unchanged.
- R10: An index that names a counter number at or above the bank's count returns zero data with `rd_fault_o` high; otherwise `rd_fault_o` is low.
- R11: A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 enable, 1 status clear, 2 fixed control, 3 none |
| wr_data_i | input | 64 | Write data |
| gp_cnt_i | input | NUM_GP*GP_W | Packed general counter values |
| fx_cnt_i | input | NUM_FX*FX_W | Packed fixed counter values |
| gp_ovf_i | input | NUM_GP | General counter overflow pulses |
| fx_ovf_i | input | NUM_FX | Fixed counter overflow pulses |
| gp_int_en_i | input | NUM_GP | Interrupt enable for each general counter |
| rd_idx_i | input | 32 | Read index word |
| glb_en_o | output | 64 | Global enable vector |
| ovf_status_o | output | 64 | Overflow status vector |
| fx_ctrl_o | output | 4*NUM_FX | Packed fixed-control word |
| gp_run_o | output | NUM_GP | Run enable for each general counter |
| fx_run_o | output | NUM_FX | Run enable for each fixed counter |
| pmi_o | output | 1 | Performance-monitor interrupt pulse |
| rd_data_o | output | 64 | Read data |
| rd_fault_o | output | 1 | Read index names no counter |

## Verification
The properties assume that overflow pulses, write strobes and the read index are stable around the rising edge and hold no X. They also assume that an overflow pulse means one event per cycle, so back-to-back overflows give back-to-back interrupt cycles instead of merged ones. The bench drives every input on the falling edge. It keeps the overflow pulses at zero while reset is held, and it confines random read indices to small counter numbers with and without the bank and truncation flags, so that both valid reads and faulting reads occur.

// File: rtl/ctr_bank_pkg.sv
package ctr_bank_pkg;
  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_FCTL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int FX_BASE  = 32;
  localparam int NIB_W    = 4;
  localparam logic [3:0] NIB_MASK = 4'b1011;
  localparam int IDX_FAST = 31;
  localparam int IDX_FX   = 30;
  localparam int IDX_NUM_W = 30;
endpackage

// File: rtl/ctr_glb_regs.sv
module ctr_glb_regs
  import ctr_bank_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [1:0]              wr_sel_i,
  input  logic [63:0]             wr_data_i,
  output logic [63:0]             en_o,
  output logic [NIB_W*NUM_FX-1:0] fctl_o,
  output logic [NUM_GP-1:0]       gp_run_o,
  output logic [NUM_FX-1:0]       fx_run_o,
  output logic [NUM_FX-1:0]       fx_pmi_en_o
);
  localparam int FC_W = NIB_W * NUM_FX;

  function automatic logic [63:0] en_mask_f();
    logic [63:0] m = '0;
    for (int i = 0; i < NUM_GP; i++) m[i] = 1'b1;
    for (int j = 0; j < NUM_FX; j++) m[FX_BASE+j] = 1'b1;
    return m;
  endfunction

  localparam logic [63:0] EN_MASK = en_mask_f();
  localparam logic [FC_W-1:0] FC_MASK = {NUM_FX{NIB_MASK}};

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  logic [63:0]     en_q;
  logic [FC_W-1:0] fc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      fc_q <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_EN)   en_q <= wr_data_i & EN_MASK;
      if (sel == SEL_FCTL) fc_q <= wr_data_i[FC_W-1:0] & FC_MASK;
    end
  end

  assign en_o     = en_q;
  assign fctl_o   = fc_q;
  assign gp_run_o = en_q[NUM_GP-1:0];

  for (genvar j = 0; j < NUM_FX; j++) begin : g_fx
    logic [NIB_W-1:0] nib;
    assign nib            = fc_q[NIB_W*j +: NIB_W];
    assign fx_run_o[j]    = en_q[FX_BASE+j] & (nib[0] | nib[1]);
    assign fx_pmi_en_o[j] = nib[3];
  end
endmodule

// File: rtl/ctr_ovf_status.sv
module ctr_ovf_status
  import ctr_bank_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_GP-1:0] gp_ovf_i,
  input  logic [NUM_FX-1:0] fx_ovf_i,
  input  logic [NUM_GP-1:0] gp_int_en_i,
  input  logic [NUM_FX-1:0] fx_pmi_en_i,
  input  logic              clr_en_i,
  input  logic [63:0]       clr_mask_i,
  output logic [63:0]       status_o,
  output logic              pmi_o
);
  logic [63:0] set_vec;
  logic [63:0] clr_vec;
  logic [63:0] st_q;
  logic        pmi_q;
  logic        pmi_d;

  always_comb begin
    set_vec = '0;
    set_vec[NUM_GP-1:0] = gp_ovf_i;
    set_vec[FX_BASE +: NUM_FX] = fx_ovf_i;
  end

  assign clr_vec = clr_en_i ? clr_mask_i : '0;
  assign pmi_d   = |(gp_ovf_i & gp_int_en_i) | |(fx_ovf_i & fx_pmi_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      pmi_q <= 1'b0;
    end else begin
      st_q  <= (st_q & ~clr_vec) | set_vec;  // set beats clear
      pmi_q <= pmi_d;
    end
  end

  assign status_o = st_q;
  assign pmi_o    = pmi_q;
endmodule

// File: rtl/ctr_rd_mux.sv
module ctr_rd_mux
  import ctr_bank_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 40,
  parameter int FX_W   = 36
) (
  input  logic [31:0]             rd_idx_i,
  input  logic [NUM_GP*GP_W-1:0]  gp_cnt_i,
  input  logic [NUM_FX*FX_W-1:0]  fx_cnt_i,
  output logic [63:0]             rd_data_o,
  output logic                    rd_fault_o
);
  logic [IDX_NUM_W-1:0] num;
  logic [63:0]          val;
  logic                 hit;

  assign num = rd_idx_i[IDX_NUM_W-1:0];

  always_comb begin
    val = '0;
    hit = 1'b0;
    if (rd_idx_i[IDX_FX]) begin
      for (int j = 0; j < NUM_FX; j++) begin
        if (num == IDX_NUM_W'(j)) begin
          val = 64'(fx_cnt_i[j*FX_W +: FX_W]);
          hit = 1'b1;
        end
      end
    end else begin
      for (int i = 0; i < NUM_GP; i++) begin
        if (num == IDX_NUM_W'(i)) begin
          val = 64'(gp_cnt_i[i*GP_W +: GP_W]);
          hit = 1'b1;
        end
      end
    end
    if (rd_idx_i[IDX_FAST]) val[63:32] = '0;
  end

  assign rd_data_o  = val;
  assign rd_fault_o = ~hit;
endmodule

// File: rtl/ctr_bank_ctrl.sv
module ctr_bank_ctrl
  import ctr_bank_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 40,
  parameter int FX_W   = 36
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [1:0]              wr_sel_i,
  input  logic [63:0]             wr_data_i,
  input  logic [NUM_GP*GP_W-1:0]  gp_cnt_i,
  input  logic [NUM_FX*FX_W-1:0]  fx_cnt_i,
  input  logic [NUM_GP-1:0]       gp_ovf_i,
  input  logic [NUM_FX-1:0]       fx_ovf_i,
  input  logic [NUM_GP-1:0]       gp_int_en_i,
  input  logic [31:0]             rd_idx_i,
  output logic [63:0]             glb_en_o,
  output logic [63:0]             ovf_status_o,
  output logic [4*NUM_FX-1:0]     fx_ctrl_o,
  output logic [NUM_GP-1:0]       gp_run_o,
  output logic [NUM_FX-1:0]       fx_run_o,
  output logic                    pmi_o,
  output logic [63:0]             rd_data_o,
  output logic                    rd_fault_o
);
  logic [NUM_FX-1:0] fx_pmi_en;
  logic              clr_en;

  assign clr_en = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CLR);

  ctr_glb_regs #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .en_o        (glb_en_o),
    .fctl_o      (fx_ctrl_o),
    .gp_run_o    (gp_run_o),
    .fx_run_o    (fx_run_o),
    .fx_pmi_en_o (fx_pmi_en)
  );

  ctr_ovf_status #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gp_ovf_i    (gp_ovf_i),
    .fx_ovf_i    (fx_ovf_i),
    .gp_int_en_i (gp_int_en_i),
    .fx_pmi_en_i (fx_pmi_en),
    .clr_en_i    (clr_en),
    .clr_mask_i  (wr_data_i),
    .status_o    (ovf_status_o),
    .pmi_o       (pmi_o)
  );

  ctr_rd_mux #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W)) u_rd (
    .rd_idx_i   (rd_idx_i),
    .gp_cnt_i   (gp_cnt_i),
    .fx_cnt_i   (fx_cnt_i),
    .rd_data_o  (rd_data_o),
    .rd_fault_o (rd_fault_o)
  );
endmodule

// File: rtl/ctr_bank_ctrl_chk.sv
module ctr_bank_ctrl_chk #(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [1:0]          wr_sel_i,
  input logic [63:0]         wr_data_i,
  input logic [NUM_GP-1:0]   gp_ovf_i,
  input logic [NUM_FX-1:0]   fx_ovf_i,
  input logic [NUM_GP-1:0]   gp_int_en_i,
  input logic [31:0]         rd_idx_i,
  input logic [63:0]         glb_en_o,
  input logic [63:0]         ovf_status_o,
  input logic [4*NUM_FX-1:0] fx_ctrl_o,
  input logic [NUM_FX-1:0]   fx_run_o,
  input logic                pmi_o,
  input logic [63:0]         rd_data_o,
  input logic                rd_fault_o
);
  logic [63:0] ovf_vec;
  logic        qual;
  logic        clr_wr;

  always_comb begin
    ovf_vec = '0;
    qual    = |(gp_ovf_i & gp_int_en_i);
    for (int i = 0; i < NUM_GP; i++) ovf_vec[i] = gp_ovf_i[i];
    for (int j = 0; j < NUM_FX; j++) begin
      ovf_vec[32+j] = fx_ovf_i[j];
      if (fx_ovf_i[j] && fx_ctrl_o[4*j+3]) qual = 1'b1;
    end
  end

  assign clr_wr = wr_en_i && (wr_sel_i == 2'd1);

  a_r4_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ovf_status_o & $past(ovf_vec)) == $past(ovf_vec)));

  a_r5_clear_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((ovf_status_o & $past(wr_data_i) & ~$past(ovf_vec)) == 64'd0));

  a_r6_set_over_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && (ovf_vec & wr_data_i) != 64'd0)
      |=> ((ovf_status_o & $past(ovf_vec & wr_data_i)) == $past(ovf_vec & wr_data_i)));

  a_r7_pmi_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual |=> pmi_o);

  a_r7_pmi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |=> !pmi_o);

  a_r3_fx_run_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fx_run_o & ~glb_en_o[32 +: NUM_FX]) == '0);

  a_r9_fast_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i[31] |-> (rd_data_o[63:32] == 32'd0));

  a_r10_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fault_o |-> (rd_data_o == 64'd0));
endmodule

bind ctr_bank_ctrl ctr_bank_ctrl_chk #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_chk (.*);

// File: tb/ctr_bank_ctrl_tb.sv
`timescale 1ns/1ps
module ctr_bank_ctrl_tb;
  localparam int NUM_GP = 4;
  localparam int NUM_FX = 3;
  localparam int GP_W   = 40;
  localparam int FX_W   = 36;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic                   wr_en;
  logic [1:0]             wr_sel;
  logic [63:0]            wr_data;
  logic [NUM_GP*GP_W-1:0] gp_cnt;
  logic [NUM_FX*FX_W-1:0] fx_cnt;
  logic [NUM_GP-1:0]      gp_ovf;
  logic [NUM_FX-1:0]      fx_ovf;
  logic [NUM_GP-1:0]      gp_int_en;
  logic [31:0]            rd_idx;
  logic [63:0]            glb_en, st;
  logic [4*NUM_FX-1:0]    fx_ctrl;
  logic [NUM_GP-1:0]      gp_run;
  logic [NUM_FX-1:0]      fx_run;
  logic                   pmi;
  logic [63:0]            rd_data;
  logic                   rd_fault;

  ctr_bank_ctrl #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .gp_cnt_i(gp_cnt), .fx_cnt_i(fx_cnt), .gp_ovf_i(gp_ovf), .fx_ovf_i(fx_ovf),
    .gp_int_en_i(gp_int_en), .rd_idx_i(rd_idx), .glb_en_o(glb_en), .ovf_status_o(st),
    .fx_ctrl_o(fx_ctrl), .gp_run_o(gp_run), .fx_run_o(fx_run), .pmi_o(pmi),
    .rd_data_o(rd_data), .rd_fault_o(rd_fault)
  );

  // Reference state
  logic [63:0] m_en, m_st, m_fc;
  logic        m_pmi;
  logic [63:0] gp_val [NUM_GP];
  logic [63:0] fx_val [NUM_FX];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [63:0] e_rd;
    logic        e_flt;
    logic [63:0] gr, fr;
    int n;
    vectors++;
    chk("R2", "glb_en", glb_en, m_en);
    chk("R4", "status", st, m_st);
    chk("R3", "fx_ctrl", 64'(fx_ctrl), m_fc);
    chk("R7", "pmi", 64'(pmi), 64'(m_pmi));
    gr = '0; fr = '0;
    for (int i = 0; i < NUM_GP; i++) gr[i] = m_en[i];
    for (int j = 0; j < NUM_FX; j++)
      fr[j] = m_en[32+j] && (m_fc[4*j] || m_fc[4*j+1]);
    chk("R2", "gp_run", 64'(gp_run), gr);
    chk("R3", "fx_run", 64'(fx_run), fr);
    n = int'(rd_idx[29:0]);
    e_rd = '0; e_flt = 1'b1;
    if (rd_idx[30]) begin
      if (n < NUM_FX) begin e_rd = fx_val[n] & ((64'd1 << FX_W) - 1); e_flt = 1'b0; end
    end else begin
      if (n < NUM_GP) begin e_rd = gp_val[n] & ((64'd1 << GP_W) - 1); e_flt = 1'b0; end
    end
    if (rd_idx[31]) e_rd = e_rd & 64'hFFFF_FFFF;
    chk(e_flt ? "R10" : (rd_idx[31] ? "R9" : "R8"), "rd_data", rd_data, e_rd);
    chk("R10", "rd_fault", 64'(rd_fault), 64'(e_flt));
  endtask

  task automatic model_step();
    logic [63:0] setv, clrv;
    logic q;
    setv = '0; q = 1'b0;
    for (int i = 0; i < NUM_GP; i++) if (gp_ovf[i]) begin
      setv[i] = 1'b1;
      if (gp_int_en[i]) q = 1'b1;
    end
    for (int j = 0; j < NUM_FX; j++) if (fx_ovf[j]) begin
      setv[32+j] = 1'b1;
      if (m_fc[4*j+3]) q = 1'b1;
    end
    clrv = (wr_en && wr_sel == 2'd1) ? wr_data : 64'd0;
    m_st  = (m_st & ~clrv) | setv;
    m_pmi = q;
    if (wr_en && wr_sel == 2'd0) begin
      m_en = '0;
      for (int i = 0; i < NUM_GP; i++) m_en[i] = wr_data[i];
      for (int j = 0; j < NUM_FX; j++) m_en[32+j] = wr_data[32+j];
    end
    if (wr_en && wr_sel == 2'd2) begin
      m_fc = '0;
      for (int j = 0; j < NUM_FX; j++) begin
        m_fc[4*j]   = wr_data[4*j];
        m_fc[4*j+1] = wr_data[4*j+1];
        m_fc[4*j+3] = wr_data[4*j+3];
      end
    end
  endtask

  task automatic pack_cnt();
    for (int i = 0; i < NUM_GP; i++) gp_cnt[i*GP_W +: GP_W] = gp_val[i][GP_W-1:0];
    for (int j = 0; j < NUM_FX; j++) fx_cnt[j*FX_W +: FX_W] = fx_val[j][FX_W-1:0];
  endtask

  // Called at a falling edge: drive, compare, advance one clock.
  task automatic cyc(input logic we, input logic [1:0] sel, input logic [63:0] d,
                     input logic [NUM_GP-1:0] go, input logic [NUM_FX-1:0] fo,
                     input logic [31:0] idx);
    wr_en = we; wr_sel = sel; wr_data = d; gp_ovf = go; fx_ovf = fo; rd_idx = idx;
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(input logic [31:0] idx);
    cyc(1'b0, 2'd0, 64'd0, '0, '0, idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    wr_en = 0; wr_sel = 0; wr_data = 0; gp_ovf = 0; fx_ovf = 0; rd_idx = 0;
    gp_int_en = 4'b1010;
    m_en = 0; m_st = 0; m_fc = 0; m_pmi = 0;
    gp_val[0] = 64'hFFFF_FF01_2345_6789; gp_val[1] = 64'h0000_00AB_CDEF_0123;
    gp_val[2] = 64'h1234_5678_9ABC_DEF0; gp_val[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    fx_val[0] = 64'hFF01_2345_6789_ABCD; fx_val[1] = 64'h0000_000F_0000_0001;
    fx_val[2] = 64'hDEAD_BEEF_CAFE_F00D;
    pack_cnt();
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    #1 compare();
    rst_ni = 1'b1;
    @(negedge clk);
    idle(32'd0);  // R1 after release
    // R2: enable write keeps only implemented bits
    cyc(1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 32'd1);
    idle(32'd2);
    // R3: fixed control write, reserved bit 2 dropped
    cyc(1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 32'h4000_0000);
    idle(32'h4000_0001);
    // R3: zero nibble 1 stops fixed counter 1; nibble 2 user only, no interrupt
    cyc(1'b1, 2'd2, 64'h0000_0000_0000_020B, '0, '0, 32'h4000_0002);
    idle(32'h8000_0000);  // R9 fast general
    // R4, R7: gp0 (no int), gp1 (int)
    cyc(1'b0, 2'd0, 0, 4'b0001, 3'b000, 32'hC000_0000);
    cyc(1'b0, 2'd0, 0, 4'b0010, 3'b000, 32'd3);
    idle(32'd4);   // R10 general out of range
    // R7: fixed 0 has nibble bit 3, fixed 2 does not
    cyc(1'b0, 2'd0, 0, 4'b0000, 3'b100, 32'h4000_0003);  // R10 fixed out of range
    cyc(1'b0, 2'd0, 0, 4'b0000, 3'b001, 32'h4000_0010);
    cyc(1'b0, 2'd0, 0, 4'b0101, 3'b000, 32'hC000_0002);
    idle(32'h8000_0003);
    // R5: partial clear
    cyc(1'b1, 2'd1, 64'h0000_0001_0000_0003, '0, '0, 32'd0);
    idle(32'd0);
    // R6: clear bit 2 while gp2 overflows again
    cyc(1'b1, 2'd1, 64'h0000_0004_0000_0004, 4'b0100, 3'b000, 32'd2);
    idle(32'd2);
    // R11: select 3 writes nothing
    cyc(1'b1, 2'd3, 64'd0, '0, '0, 32'd1);
    idle(32'd1);
    // back-to-back qualifying overflows
    cyc(1'b0, 2'd0, 0, 4'b1000, 3'b000, 32'd3);
    cyc(1'b0, 2'd0, 0, 4'b1000, 3'b000, 32'd3);
    idle(32'd3);
    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] idx;
      logic [63:0] d;
      if (k % 50 == 0) begin
        for (int i = 0; i < NUM_GP; i++) gp_val[i] = {$urandom, $urandom};
        for (int j = 0; j < NUM_FX; j++) fx_val[j] = {$urandom, $urandom};
        pack_cnt();
        gp_int_en = 4'($urandom);
      end
      idx = {2'($urandom), 27'd0, 3'($urandom_range(0, 5))};
      d = {$urandom, $urandom};
      cyc(($urandom % 3) == 0, 2'($urandom), d,
          (($urandom % 4) == 0) ? 4'($urandom) : 4'd0,
          (($urandom % 4) == 0) ? 3'($urandom) : 3'd0, idx);
    end
    idle(32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule